// File: doc/BRIEF.md
# Strobed Parallel Port Handshake

This block runs a two-wire interlocked handshake on an 8-bit parallel port. A direction select decides which side owns which wire. In input mode, a peripheral drives an active-low strobe. The block captures the port byte once it sees that strobe low, and it answers on its own acknowledge wire. In output mode, the block drives the byte and lowers its own strobe. It then waits for the peripheral to pull the acknowledge wire low and release it again.

The strobe and acknowledge inputs come from outside the clock domain. Each passes through a synchronizer before any decision is taken on it. On the core side there are two interfaces. A load port hands a byte over for transmission. A read strobe consumes the captured byte. A single flag shows whether a received byte is waiting (input mode) or whether the transmitter is free for a new byte (output mode). A separate overrun flag records any load attempt that arrived while a transfer was still in progress.

Top module: `strobe_hs_port`

## Requirements
- R1: After synchronous reset: `strb_out_n` is 1, `ack_out` is 1, `xfer_flag` is 0 and `overrun` is 0. `dir_out` is 0 selects input mode and 1 selects output mode.
- R2: In input mode with the receiver idle, a low level on `strb_in_n` makes the block capture `pin_data_in`. The captured byte appears on `rd_data`, and `xfer_flag` becomes 1.
- R3: In input mode, `ack_out` goes low when a byte is captured. It returns high only after two things have happened: `strb_in_n` has been seen high again, and the byte has been read. The two may occur in either order.
- R4: A pulse on `rd_strobe` clears `xfer_flag` in input mode. A read when no byte is waiting changes neither `rd_data` nor `xfer_flag`.
- R5: In output mode, an accepted load places the byte on `pin_data_out`, with `pin_data_oe` at 1. This happens at least one clock before `strb_out_n` falls.
- R6: `strb_out_n` falls only while the synchronized `ack_in` is high. It rises only after the synchronized `ack_in` has gone low.
- R7: After `strb_out_n` rises, the transfer stays open (`xfer_flag` 0 in output mode) until the synchronized `ack_in` is high again. No new transfer can start before that.
- R8: A load while a transfer is open is refused: `pin_data_out` keeps its byte and `overrun` becomes 1. The next accepted load clears `overrun`.
- R9: In output mode, `ack_out` is 1 and a low `strb_in_n` captures nothing. In input mode, `strb_out_n` is 1, `pin_data_oe` is 0, and loads change neither `pin_data_out` nor `overrun`.
- R10: A level change on `strb_in_n` or `ack_in` takes effect on the third rising clock edge after it is applied: two synchronizer stages, then one state update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dir_out | input | 1 | 1 selects output mode, 0 selects input mode |
| pin_data_in | input | 8 | Port byte from the pads |
| pin_data_out | output | 8 | Port byte to the pads |
| pin_data_oe | output | 1 | Pad output enable for the port byte |
| strb_in_n | input | 1 | Peripheral's active-low data strobe (input mode) |
| strb_out_n | output | 1 | Block's active-low data strobe (output mode) |
| ack_in | input | 1 | Peripheral's acknowledge wire (output mode) |
| ack_out | output | 1 | Block's acknowledge wire (input mode) |
| load_valid | input | 1 | Core offers a byte to transmit |
| load_data | input | 8 | Byte to transmit |
| rd_strobe | input | 1 | Core consumes the captured byte |
| rd_data | output | 8 | Last captured byte |
| xfer_flag | output | 1 | Input mode: byte waiting; output mode: transmitter free |
| overrun | output | 1 | A load was refused since the last accepted load |

## Verification
Two situations are hard to reach from the ports. The first is a load arriving while the block's own strobe is low and the peripheral is deliberately holding its acknowledge high; the bench parks the acknowledge wire to keep the transfer open and then issues the refused load. The second is a core read that lands before the peripheral's strobe rises; the bench holds the strobe low across the read and checks that `ack_out` returns high only after the strobe is released. A transfer started while the peripheral still holds acknowledge low shows that the strobe waits rather than falling early.

// File: rtl/hs_pkg.sv
// Package: shared state encodings for the strobed port handshake.
// Assumes: nothing beyond being compiled ahead of the modules that import it.
package hs_pkg;

    // Receive side: idle, waiting for the peripheral strobe to rise, waiting for a core read
    typedef enum logic [1:0] {
        RX_IDLE      = 2'd0,
        RX_WAIT_RISE = 2'd1,
        RX_WAIT_READ = 2'd2
    } rx_state_t;

    // Transmit side: idle, data set up, strobe low, waiting for acknowledge release
    typedef enum logic [1:0] {
        TX_IDLE      = 2'd0,
        TX_SETUP     = 2'd1,
        TX_WAIT_LOW  = 2'd2,
        TX_WAIT_HIGH = 2'd3
    } tx_state_t;

endpackage

// File: rtl/hs_sync.sv
// Module: hs_sync
// Multi-stage synchronizer bank. WIDTH independent bits each pass through
// STAGES flops. Assumes each bit is a slow level signal that needs no
// relationship kept between bits; reset loads RESET_VAL into every stage.
module hs_sync #(
    parameter int              WIDTH     = 2,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single stage: sample the pins directly
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[0] <= RESET_VAL;
                else        chain_q[0] <= d;
            end
        end else begin : g_multi
            // Shift chain: stage 0 samples the pins, each later stage copies the one before
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q <= {STAGES{RESET_VAL}};
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], d};
                end
            end
        end
    endgenerate

    assign q = chain_q[LAST];

endmodule

// File: rtl/hs_rx_engine.sv
// Module: hs_rx_engine
// Receive half of the handshake. Captures the port byte when the
// synchronized peripheral strobe is low and the engine is idle. Holds the
// acknowledge low until the strobe has risen and the core has read the byte.
// Assumes strb_sync_n is already synchronized, and that the peripheral keeps
// the data stable while its strobe is low. When en is low the engine does
// not capture, but a pending byte remains readable.
module hs_rx_engine
    import hs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              strb_sync_n,
    input  logic [DATA_W-1:0] pin_data,
    input  logic              rd_strobe,
    output logic              ack_rdy,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    rx_state_t         state_q, state_d;
    logic              full_q, full_d;
    logic [DATA_W-1:0] data_q;
    logic              capture;

    assign capture = en && (state_q == RX_IDLE) && !strb_sync_n;

    // Next value of the byte-waiting flag: set on capture, cleared by a read
    always_comb begin
        if (capture)        full_d = 1'b1;
        else if (rd_strobe) full_d = 1'b0;
        else                full_d = full_q;
    end

    // Next receive state from the strobe level and the byte-waiting flag
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = full_d ? RX_WAIT_READ : RX_IDLE;
        end else begin
            unique case (state_q)
                RX_IDLE:      if (capture)     state_d = RX_WAIT_RISE;
                RX_WAIT_RISE: if (strb_sync_n) state_d = full_d ? RX_WAIT_READ : RX_IDLE;
                RX_WAIT_READ: if (!full_d)     state_d = RX_IDLE;
                default:                       state_d = RX_IDLE;
            endcase
        end
    end

    // State and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            full_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            full_q  <= full_d;
        end
    end

    // Capture register for the port byte
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (capture) data_q <= pin_data;
    end

    assign ack_rdy = (state_q == RX_IDLE);
    assign full    = full_q;
    assign data    = data_q;

    AST_ACK_LOW_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full_q |-> !ack_rdy); // R3
    AST_CAPTURE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_q) |-> $past(!strb_sync_n)); // R2
    AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !ack_rdy) |=> !full_q); // R4

endmodule

// File: rtl/hs_tx_engine.sv
// Module: hs_tx_engine
// Transmit half of the handshake. It accepts a byte only when idle, then
// holds the data one or more cycles before lowering its strobe. The strobe
// is lowered only while the acknowledge is high, and raised once the
// acknowledge falls. The transfer ends when the acknowledge is high again.
// A load offered during a transfer is refused and flagged as overrun.
// Assumes ack_sync is already synchronized. When en is low the engine
// returns to idle and ignores loads.
module hs_tx_engine
    import hs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              ack_sync,
    input  logic              load_valid,
    input  logic [DATA_W-1:0] load_data,
    output logic              strb_n,
    output logic [DATA_W-1:0] data,
    output logic              idle,
    output logic              overrun
);
    tx_state_t         state_q, state_d;
    logic              strb_n_q;
    logic [DATA_W-1:0] data_q;
    logic              ovr_q;
    logic              accept;
    logic              refuse;

    assign accept = en && load_valid && (state_q == TX_IDLE);
    assign refuse = en && load_valid && (state_q != TX_IDLE);

    // Next transmit state from loads and the acknowledge level
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = TX_IDLE;
        end else begin
            unique case (state_q)
                TX_IDLE:      if (accept)    state_d = TX_SETUP;
                TX_SETUP:     if (ack_sync)  state_d = TX_WAIT_LOW;
                TX_WAIT_LOW:  if (!ack_sync) state_d = TX_WAIT_HIGH;
                TX_WAIT_HIGH: if (ack_sync)  state_d = TX_IDLE;
                default:                     state_d = TX_IDLE;
            endcase
        end
    end

    // State register and registered strobe pin (low only while waiting for acknowledge)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= TX_IDLE;
            strb_n_q <= 1'b1;
        end else begin
            state_q  <= state_d;
            strb_n_q <= (state_d != TX_WAIT_LOW);
        end
    end

    // Transmit data register, written only by an accepted load
    always_ff @(posedge clk) begin
        if (!rst_n)      data_q <= '0;
        else if (accept) data_q <= load_data;
    end

    // Sticky overrun: set by a refused load, cleared by an accepted one
    always_ff @(posedge clk) begin
        if (!rst_n)      ovr_q <= 1'b0;
        else if (accept) ovr_q <= 1'b0;
        else if (refuse) ovr_q <= 1'b1;
    end

    assign strb_n  = strb_n_q;
    assign data    = data_q;
    assign idle    = (state_q == TX_IDLE);
    assign overrun = ovr_q;

    AST_STROBE_FALL_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strb_n_q) |-> $past(ack_sync)); // R6
    AST_STROBE_RISE_AFTER_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(strb_n_q) && $past(en)) |-> !$past(ack_sync)); // R6
    AST_SETUP_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strb_n_q) |-> ($past(state_q) == TX_SETUP)); // R5
    AST_DATA_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != TX_IDLE) |=> $stable(data_q)); // R8
    AST_OVERRUN_ON_REFUSAL: assert property (@(posedge clk) disable iff (!rst_n)
        refuse |=> ovr_q); // R8

endmodule

// File: rtl/strobe_hs_port.sv
// Module: strobe_hs_port
// Top of the strobed parallel port handshake. It synchronizes the two
// handshake inputs, runs the receive or transmit engine according to
// dir_out, and selects the pins and status for the active direction.
// Assumes the pad ring turns pin_data_out/pin_data_oe into a bidirectional
// port, and that dir_out changes only between transfers.
module strobe_hs_port
    import hs_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_out,
    input  logic [DATA_W-1:0] pin_data_in,
    output logic [DATA_W-1:0] pin_data_out,
    output logic              pin_data_oe,
    input  logic              strb_in_n,
    output logic              strb_out_n,
    input  logic              ack_in,
    output logic              ack_out,
    input  logic              load_valid,
    input  logic [DATA_W-1:0] load_data,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rd_data,
    output logic              xfer_flag,
    output logic              overrun
);
    localparam int SYNC_W = 2;

    logic [SYNC_W-1:0] sync_q;
    logic              strb_sync_n;
    logic              ack_sync;
    logic              rx_ack_rdy;
    logic              rx_full;
    logic              tx_idle;

    hs_sync #(
        .WIDTH     (SYNC_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL ({SYNC_W{1'b1}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ack_in, strb_in_n}),
        .q     (sync_q)
    );

    assign strb_sync_n = sync_q[0];
    assign ack_sync    = sync_q[1];

    hs_rx_engine #(.DATA_W(DATA_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (!dir_out),
        .strb_sync_n (strb_sync_n),
        .pin_data    (pin_data_in),
        .rd_strobe   (rd_strobe),
        .ack_rdy     (rx_ack_rdy),
        .full        (rx_full),
        .data        (rd_data)
    );

    hs_tx_engine #(.DATA_W(DATA_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (dir_out),
        .ack_sync   (ack_sync),
        .load_valid (load_valid),
        .load_data  (load_data),
        .strb_n     (strb_out_n),
        .data       (pin_data_out),
        .idle       (tx_idle),
        .overrun    (overrun)
    );

    // Pin and status selection by direction
    always_comb begin
        pin_data_oe = dir_out;
        ack_out     = dir_out | rx_ack_rdy;
        xfer_flag   = dir_out ? tx_idle : rx_full;
    end

    AST_INPUT_MODE_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_out && $past(!dir_out)) |-> (strb_out_n && !pin_data_oe)); // R9
    AST_OUTPUT_MODE_ACK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        dir_out |-> ack_out); // R9

endmodule

// File: tb/test_strobe_hs_port.sv
// Bench for strobe_hs_port: a behavioural reference model updated on every
// rising edge and compared on every falling edge, plus directed checks.
module test_strobe_hs_port;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir_out = 1'b0;
    logic [7:0] pin_data_in = 8'h00;
    logic [7:0] pin_data_out;
    logic       pin_data_oe;
    logic       strb_in_n = 1'b1;
    logic       strb_out_n;
    logic       ack_in = 1'b1;
    logic       ack_out;
    logic       load_valid = 1'b0;
    logic [7:0] load_data = 8'h00;
    logic       rd_strobe = 1'b0;
    logic [7:0] rd_data;
    logic       xfer_flag;
    logic       overrun;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strobe_hs_port i_strobe_hs_port (
        .clk(clk), .rst_n(rst_n), .dir_out(dir_out),
        .pin_data_in(pin_data_in), .pin_data_out(pin_data_out), .pin_data_oe(pin_data_oe),
        .strb_in_n(strb_in_n), .strb_out_n(strb_out_n),
        .ack_in(ack_in), .ack_out(ack_out),
        .load_valid(load_valid), .load_data(load_data),
        .rd_strobe(rd_strobe), .rd_data(rd_data),
        .xfer_flag(xfer_flag), .overrun(overrun)
    );

    // ---------------- reference model ----------------
    int m_ps1, m_ps2, m_as1, m_as2;   // two-stage delayed strobe / acknowledge
    int m_rx;                         // 0 free, 1 strobe still low, 2 awaiting read
    int m_full, m_rxbyte;
    int m_tx;                         // 0 free, 1 setup, 2 strobe low, 3 waiting release
    int m_txbyte, m_strb, m_ovr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ps1 = 1; m_ps2 = 1; m_as1 = 1; m_as2 = 1;
            m_rx = 0; m_full = 0; m_rxbyte = 0;
            m_tx = 0; m_txbyte = 0; m_strb = 1; m_ovr = 0;
        end else begin
            int took, nf, tx_old;
            took = (!dir_out && m_rx == 0 && m_ps2 == 0) ? 1 : 0;
            nf = m_full;
            if (took) begin nf = 1; m_rxbyte = pin_data_in; end
            else if (rd_strobe) nf = 0;
            if (dir_out)                       m_rx = nf ? 2 : 0;
            else if (m_rx == 0)                m_rx = took ? 1 : 0;
            else if (m_rx == 1 && m_ps2 == 1)  m_rx = nf ? 2 : 0;
            else if (m_rx == 2 && nf == 0)     m_rx = 0;
            m_full = nf;

            tx_old = m_tx;
            if (!dir_out) begin
                m_tx = 0;
            end else begin
                if (load_valid) begin
                    if (tx_old == 0) begin m_txbyte = load_data; m_ovr = 0; m_tx = 1; end
                    else m_ovr = 1;
                end
                if (tx_old == 1 && m_as2 == 1) m_tx = 2;
                if (tx_old == 2 && m_as2 == 0) m_tx = 3;
                if (tx_old == 3 && m_as2 == 1) m_tx = 0;
            end
            m_strb = (m_tx == 2) ? 0 : 1;

            m_ps2 = m_ps1; m_ps1 = strb_in_n;
            m_as2 = m_as1; m_as1 = ack_in;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R3", "ack_out",      int'(ack_out),      (dir_out || m_rx == 0) ? 1 : 0);
            chk("R6", "strb_out_n",   int'(strb_out_n),   m_strb);
            chk("R5", "pin_data_out", int'(pin_data_out), m_txbyte);
            chk("R9", "pin_data_oe",  int'(pin_data_oe),  int'(dir_out));
            chk("R2", "rd_data",      int'(rd_data),      m_rxbyte);
            chk("R4", "xfer_flag",    int'(xfer_flag),    dir_out ? ((m_tx == 0) ? 1 : 0) : m_full);
            chk("R8", "overrun",      int'(overrun),      m_ovr);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_read();
        rd_strobe = 1'b1; step(1); rd_strobe = 1'b0;
    endtask

    task automatic pulse_load(input logic [7:0] v);
        load_data = v; load_valid = 1'b1; step(1); load_valid = 1'b0;
    endtask

    // Full input transfer with the read after the strobe rises
    task automatic rx_byte(input logic [7:0] v);
        pin_data_in = v; strb_in_n = 1'b0;
        step(3);
        chk("R2", "capture flag", int'(xfer_flag), 1);
        chk("R2", "captured byte", int'(rd_data), int'(v));
        strb_in_n = 1'b1; step(4);
        chk("R3", "ack held until read", int'(ack_out), 0);
        pulse_read();
        chk("R3", "ack after read", int'(ack_out), 1);
        chk("R4", "flag after read", int'(xfer_flag), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1", "strb_out_n", int'(strb_out_n), 1);
        chk("R1", "ack_out", int'(ack_out), 1);
        chk("R1", "xfer_flag", int'(xfer_flag), 0);
        chk("R1", "overrun", int'(overrun), 0);

        // R10 latency and R2 capture
        pin_data_in = 8'hC3; strb_in_n = 1'b0;
        step(2);
        chk("R10", "ack before 3rd edge", int'(ack_out), 1);
        step(1);
        chk("R10", "ack on 3rd edge", int'(ack_out), 0);
        chk("R2", "rd_data", int'(rd_data), 'hC3);
        // R3 read while strobe still low: ack stays low
        pulse_read();
        chk("R4", "flag cleared", int'(xfer_flag), 0);
        step(3);
        chk("R3", "ack low until strobe rises", int'(ack_out), 0);
        strb_in_n = 1'b1;
        step(2);
        chk("R3", "ack low before strobe seen", int'(ack_out), 0);
        step(1);
        chk("R3", "ack high after strobe seen", int'(ack_out), 1);
        // R4 read with nothing waiting
        pulse_read();
        chk("R4", "idle read keeps data", int'(rd_data), 'hC3);
        chk("R4", "idle read keeps flag", int'(xfer_flag), 0);

        rx_byte(8'h00);
        rx_byte(8'hFF);
        rx_byte(8'h5A);

        // Output mode
        dir_out = 1'b1;
        step(1);
        chk("R9", "ack_out in output mode", int'(ack_out), 1);
        chk("R9", "oe in output mode", int'(pin_data_oe), 1);
        // R9 strobe in ignored in output mode
        strb_in_n = 1'b0; step(5);
        chk("R9", "no capture in output", int'(rd_data), 'h5A);
        strb_in_n = 1'b1; step(3);

        pulse_load(8'hA5);
        chk("R5", "data driven", int'(pin_data_out), 'hA5);
        chk("R5", "strobe still high in setup", int'(strb_out_n), 1);
        step(1);
        chk("R6", "strobe low", int'(strb_out_n), 0);
        // R8 refused load
        pulse_load(8'h11);
        chk("R8", "data kept", int'(pin_data_out), 'hA5);
        chk("R8", "overrun set", int'(overrun), 1);
        step(3);
        chk("R6", "strobe waits for ack low", int'(strb_out_n), 0);
        ack_in = 1'b0;
        step(2);
        chk("R6", "strobe before ack seen", int'(strb_out_n), 0);
        step(1);
        chk("R6", "strobe raised", int'(strb_out_n), 1);
        chk("R7", "transfer open", int'(xfer_flag), 0);
        pulse_load(8'h22);
        chk("R8", "refused while open", int'(pin_data_out), 'hA5);
        step(4);
        chk("R7", "still open", int'(xfer_flag), 0);
        ack_in = 1'b1;
        step(2);
        chk("R7", "open before ack high seen", int'(xfer_flag), 0);
        step(1);
        chk("R7", "closed", int'(xfer_flag), 1);

        // Transfer started while acknowledge is low
        ack_in = 1'b0; step(3);
        pulse_load(8'h3C);
        chk("R8", "overrun cleared by accept", int'(overrun), 0);
        chk("R5", "new data", int'(pin_data_out), 'h3C);
        step(6);
        chk("R6", "strobe waits for ack high", int'(strb_out_n), 1);
        ack_in = 1'b1;
        step(3);
        chk("R6", "strobe falls after ack high", int'(strb_out_n), 0);
        ack_in = 1'b0; step(3);
        chk("R6", "strobe up", int'(strb_out_n), 1);
        ack_in = 1'b1; step(3);
        chk("R7", "done", int'(xfer_flag), 1);

        // Back to input mode: loads ignored
        dir_out = 1'b0;
        step(1);
        chk("R9", "strobe high in input", int'(strb_out_n), 1);
        chk("R9", "oe low in input", int'(pin_data_oe), 0);
        pulse_load(8'h99);
        step(1);
        chk("R9", "load ignored data", int'(pin_data_out), 'h3C);
        chk("R9", "load ignored overrun", int'(overrun), 0);
        chk("R9", "no stray capture", int'(xfer_flag), 0);

        rx_byte(8'h96);
        step(2);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule